// File: doc/BRIEF.md
# Character Cell Fetch and Pixel Shifter

This block turns a text screen held in video RAM into a serial pixel stream. While the display window is open, it spends eight pixel clocks on each character cell. In the first half of the cell it reads the character code and then the matching font byte from one synchronous read port. In the second half it leaves that port alone. The font byte goes into a serial shifter that runs at the pixel rate, and a separate inverse flag is held next to it and applied to those eight pixels.

An external timing generator supplies the display-window flag together with the column, character-row and scan-line counters. That generator holds each column value for one whole cell, and it advances the row after scan line 7. The read port sees a chip select pulse inside each cell instead of one long select per line, so the other side of a dual-port RAM is kept out for only four clocks at a time. Pixels for a column come out one cell after that column is fetched. When a line ends, the shifter and the inverse flag are both returned to background.

Top module: `charcell_shifter`

## Requirements
- R1: While reset is low, `vid_px` and `inv_flag` are 0. With `disp_act` low, `vram_cs` is also 0, and any line that was in progress is dropped.
- R2: Counting from the first clock with `disp_act` high, each 8-clock cell drives `vram_cs` high on its clocks 0 to 3 and low on clocks 4 to 7. `vram_cs` is low on every clock where `disp_act` is low.
- R3: On clock 0 of a cell, `vram_addr` equals `row*32 + col`. The character code area starts at address 0, and the port returns data one clock after it samples an address with `vram_cs` high.
- R4: On clocks 2 and 3 of a cell, `vram_addr` equals `1024 + code[6:0]*8 + line`, where `code` is the byte that came back for clock 0 of that cell.
- R5: The 8 pixels of column c leave on `vid_px` most significant bit first. Bit 7-j of the font byte appears on clock 8*(c+1)+j, counted from the first active clock, and consecutive columns follow with no gap.
- R6: When bit 7 of a code is 1, all 8 pixels of that column are inverted. `inv_flag` shows that bit on the same 8 clocks and holds it steady across them.
- R7: `inv_flag` is 0 on every clock after the last pixel of a line, up to the first pixel of the next line.
- R8: `vid_px` is 0 on every clock where no column's pixels are being shown: before the first column of a line and after its last.
- R9: Code 0x00 gives 8 background pixels and code 0xFF gives 8 ink pixels (`vid_px` = 1), provided the font holds zero bytes for glyphs 0 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_act | input | 1 | Display window open; cells are fetched while high |
| col | input | 5 | Character column, held for a whole cell |
| row | input | 5 | Character row (0 to 23) |
| line | input | 3 | Scan line within the character row |
| vram_addr | output | 11 | Video RAM read address |
| vram_cs | output | 1 | Video RAM chip select, active high |
| vram_rd_data | input | 8 | Data read from video RAM, one clock after the address |
| vid_px | output | 1 | Serial pixel, 1 = ink |
| inv_flag | output | 1 | Inverse flag latched for the column now being shown |

## Verification
The assertions assume three things about the inputs. First, `disp_act` rises at a cell boundary and stays high for a whole number of cells. Second, `col`, `row` and `line` do not change inside a cell. Third, the RAM answers with exactly one clock of latency. The stimulus drives a full line of 32 cells every time, moves `col` only when the bench's own cell count wraps, and leaves idle gaps between lines. The RAM model in the bench follows the same single-clock read latency. The one exception is a reset in the middle of a line: there the bench drops `disp_act` together with reset, and this is the only place a cell is cut short.

// File: rtl/charcell_pkg.sv
package charcell_pkg;

   // Which of the two reads a cell is doing on the shared port.
   typedef enum logic [1:0] {
      ST_CODE_RD = 2'd0,
      ST_FONT_RD = 2'd1,
      ST_QUIET   = 2'd2
   } cc_step_e;

endpackage

// File: rtl/cc_slot_seq.sv
module cc_slot_seq
   import charcell_pkg::*;
#(
   parameter int PIX     = 8,
   parameter int CS_CLKS = 4,
   localparam int PW     = $clog2(PIX)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     act,
   output cc_step_e step,
   output logic     cs,
   output logic     cap_code,
   output logic     cap_bits,
   output logic     load
);

   logic [PW-1:0] ph;

   // Phase counter: held at 0 outside the window, wraps every cell.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ph <= '0;
      else if (!act)                 ph <= '0;
      else if (ph == PW'(PIX - 1))   ph <= '0;
      else                           ph <= ph + PW'(1);
   end

   always_comb begin
      if (ph < PW'(2))               step = ST_CODE_RD;
      else if (ph < PW'(CS_CLKS))    step = ST_FONT_RD;
      else                           step = ST_QUIET;
   end

   assign cs       = act && (ph < PW'(CS_CLKS));
   assign cap_code = act && (ph == PW'(1));
   assign cap_bits = act && (ph == PW'(3));
   assign load     = act && (ph == PW'(PIX - 1));

endmodule

// File: rtl/cc_addr_gen.sv
module cc_addr_gen
   import charcell_pkg::*;
#(
   parameter int COLS      = 32,
   parameter int DW        = 8,
   parameter int AW        = 11,
   parameter int FONT_BASE = 1024,
   parameter int CW        = 5,
   parameter int RW        = 5,
   parameter int LW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cc_step_e      step,
   input  logic          cap_code,
   input  logic [CW-1:0] col,
   input  logic [RW-1:0] row,
   input  logic [LW-1:0] line,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] addr,
   output logic          code_inv
);

   logic [DW-1:0] code_q;
   logic [AW-1:0] code_addr;
   logic [AW-1:0] font_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= '0;
      else if (cap_code) code_q <= rd_data;
   end

   assign code_addr = AW'(row) * AW'(COLS) + AW'(col);
   assign font_addr = AW'(FONT_BASE) + AW'({code_q[DW-2:0], line});
   assign code_inv  = code_q[DW-1];

   always_comb begin
      case (step)
         ST_CODE_RD: addr = code_addr;
         ST_FONT_RD: addr = font_addr;
         default:    addr = font_addr;
      endcase
   end

endmodule

// File: rtl/cc_pix_shift.sv
module cc_pix_shift #(
   parameter int DW        = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CNTW     = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_bits,
   input  logic          load,
   input  logic          code_inv,
   input  logic [DW-1:0] rd_data,
   output logic          vid_px,
   output logic          inv_flag
);

   logic [DW-1:0]   bits_q;
   logic            inv_pend;
   logic [DW-1:0]   sh;
   logic [DW-1:0]   sh_next;
   logic            out_bit;
   logic            inv_lat;
   logic [CNTW-1:0] ocnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = sh[DW-1];
         assign sh_next = {sh[DW-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit = sh[0];
         assign sh_next = {1'b0, sh[DW-1:1]};
      end
   endgenerate

   // Holding stage: font byte and inverse bit wait here until the cell ends.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q   <= '0;
         inv_pend <= 1'b0;
      end else if (cap_bits) begin
         bits_q   <= rd_data;
         inv_pend <= code_inv;
      end
   end

   // Output stage: gapless reload, cleared when the last column drains.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         inv_lat <= 1'b0;
         ocnt    <= '0;
      end else if (load) begin
         sh      <= bits_q;
         inv_lat <= inv_pend;
         ocnt    <= CNTW'(DW);
      end else if (ocnt == CNTW'(1)) begin
         sh      <= '0;
         inv_lat <= 1'b0;
         ocnt    <= '0;
      end else if (ocnt != '0) begin
         sh      <= sh_next;
         ocnt    <= ocnt - CNTW'(1);
      end
   end

   assign vid_px   = (ocnt != '0) && (out_bit ^ inv_lat);
   assign inv_flag = inv_lat;

endmodule

// File: rtl/charcell_shifter.sv
module charcell_shifter
   import charcell_pkg::*;
#(
   parameter int COLS      = 32,
   parameter int ROWS      = 24,
   parameter int LINES     = 8,
   parameter int DW        = 8,
   parameter int AW        = 11,
   parameter int FONT_BASE = 1024,
   parameter int CS_CLKS   = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CW       = $clog2(COLS),
   localparam int RW       = $clog2(ROWS),
   localparam int LW       = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_act,
   input  logic [CW-1:0] col,
   input  logic [RW-1:0] row,
   input  logic [LW-1:0] line,
   output logic [AW-1:0] vram_addr,
   output logic          vram_cs,
   input  logic [DW-1:0] vram_rd_data,
   output logic          vid_px,
   output logic          inv_flag
);

   localparam int PIX = DW;

   generate
      if (CS_CLKS < 4 || CS_CLKS >= PIX) begin : g_bad_cs
         $error("CS_CLKS must cover two reads and leave a quiet clock");
      end
      if ((1 << LW) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two");
      end
      if (ROWS * COLS > FONT_BASE) begin : g_bad_base
         $error("code area overlaps the font area");
      end
      if (FONT_BASE + (1 << (DW - 1)) * LINES > (1 << AW)) begin : g_bad_aw
         $error("font area does not fit the address width");
      end
   endgenerate

   cc_step_e step;
   logic     cap_code;
   logic     cap_bits;
   logic     load;
   logic     code_inv;

   cc_slot_seq #(.PIX(PIX), .CS_CLKS(CS_CLKS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (disp_act),
      .step     (step),
      .cs       (vram_cs),
      .cap_code (cap_code),
      .cap_bits (cap_bits),
      .load     (load)
   );

   cc_addr_gen #(
      .COLS(COLS), .DW(DW), .AW(AW), .FONT_BASE(FONT_BASE),
      .CW(CW), .RW(RW), .LW(LW)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .cap_code (cap_code),
      .col      (col),
      .row      (row),
      .line     (line),
      .rd_data  (vram_rd_data),
      .addr     (vram_addr),
      .code_inv (code_inv)
   );

   cc_pix_shift #(.DW(DW), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_bits (cap_bits),
      .load     (load),
      .code_inv (code_inv),
      .rd_data  (vram_rd_data),
      .vid_px   (vid_px),
      .inv_flag (inv_flag)
   );

endmodule

// File: rtl/charcell_shifter_chk.sv
module charcell_shifter_chk #(
   parameter int PIX     = 8,
   parameter int CS_CLKS = 4,
   parameter int AW      = 11,
   localparam int PW     = $clog2(PIX),
   localparam int CNTW   = $clog2(PIX + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          act,
   input logic          vram_cs,
   input logic [AW-1:0] vram_addr,
   input logic          vid_px,
   input logic          inv_flag
);

   logic [PW-1:0]   kph;
   logic [CNTW-1:0] kout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kph  <= '0;
         kout <= '0;
      end else begin
         kph <= (!act || kph == PW'(PIX - 1)) ? '0 : kph + PW'(1);
         if (act && kph == PW'(PIX - 1)) kout <= CNTW'(PIX);
         else if (kout != '0)            kout <= kout - CNTW'(1);
      end
   end

   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !vram_cs);                                          // R2
   AST_CS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (act && kph < PW'(CS_CLKS)) |-> vram_cs);                    // R2
   AST_CS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (act && kph >= PW'(CS_CLKS)) |-> !vram_cs);                  // R2
   AST_FONT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act && kph == PW'(2)) |=> (vram_addr == $past(vram_addr))); // R4
   AST_BG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (kout == '0) |-> !vid_px);                                   // R8
   AST_INV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (kout == '0) |-> !inv_flag);                                 // R7
   AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kout > CNTW'(1)) |=> $stable(inv_flag));                    // R6

endmodule

bind charcell_shifter charcell_shifter_chk #(
   .PIX(DW), .CS_CLKS(CS_CLKS), .AW(AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .act       (disp_act),
   .vram_cs   (vram_cs),
   .vram_addr (vram_addr),
   .vid_px    (vid_px),
   .inv_flag  (inv_flag)
);

// File: tb/sim_charcell_shifter.sv
module sim_charcell_shifter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_act = 1'b0;
   logic [4:0]  col = '0;
   logic [4:0]  row = '0;
   logic [2:0]  line = '0;
   logic [10:0] vram_addr;
   logic        vram_cs;
   logic [7:0]  vram_rd_data = '0;
   logic        vid_px;
   logic        inv_flag;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [7:0] mem [0:2047];

   always #10 clk = ~clk;

   always @(posedge clk) if (vram_cs) vram_rd_data <= mem[vram_addr];

   charcell_shifter u0 (
      .clk (clk), .rst_n (rst_n), .disp_act (disp_act),
      .col (col), .row (row), .line (line),
      .vram_addr (vram_addr), .vram_cs (vram_cs),
      .vram_rd_data (vram_rd_data),
      .vid_px (vid_px), .inv_flag (inv_flag)
   );

   function automatic int font_val(int g, int l);
      if (g == 0 || g == 127) return 0;
      return ((g * 37 + l * 11 + 5) ^ (l << 4)) & 255;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int actv, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
      end
   endtask

   // One full 32-column line plus a tail; all checks derived from R2..R9.
   task automatic run_line(input int r, input int ln, input string pix_tag);
      int e_pix = 0, e_inv = 0, e_bg = 0, e_clr = 0;
      int e_cs = 0, e_ca = 0, e_fa = 0;
      for (int t = 0; t < 268; t++) begin
         @(negedge clk);
         if (t >= 8 && t < 264) begin
            int c = (t - 8) / 8;
            int j = (t - 8) % 8;
            int code = mem[r * 32 + c];
            int g = font_val(code & 127, ln);
            int ev = ((g >> (7 - j)) & 1) ^ ((code >> 7) & 1);
            if (int'(vid_px) != ev) e_pix++;
            if (int'(inv_flag) != ((code >> 7) & 1)) e_inv++;
         end else begin
            if (vid_px !== 1'b0) e_bg++;
            if (inv_flag !== 1'b0) e_clr++;
         end
         if (t == 0) begin
            row  = 5'(r);
            line = 3'(ln);
         end
         disp_act = (t < 256);
         col      = (t < 256) ? 5'(t / 8) : 5'(0);
         #1;
         if (int'(vram_cs) != ((t < 256 && t % 8 < 4) ? 1 : 0)) e_cs++;
         if (t < 256 && t % 8 == 0 && int'(vram_addr) != r * 32 + t / 8) e_ca++;
         if (t < 256 && (t % 8 == 2 || t % 8 == 3)) begin
            int code = mem[r * 32 + t / 8];
            if (int'(vram_addr) != 1024 + (code & 127) * 8 + ln) e_fa++;
         end
      end
      check(e_pix == 0, pix_tag, "pixel stream mismatched clocks", e_pix, 0);
      check(e_inv == 0, "R6", "inv_flag in window mismatched clocks", e_inv, 0);
      check(e_bg == 0,  "R8", "background outside window mismatched clocks", e_bg, 0);
      check(e_clr == 0, "R7", "inv_flag outside window mismatched clocks", e_clr, 0);
      check(e_cs == 0,  "R2", "chip select pattern mismatched clocks", e_cs, 0);
      check(e_ca == 0,  "R3", "code address mismatched clocks", e_ca, 0);
      check(e_fa == 0,  "R4", "font address mismatched clocks", e_fa, 0);
   endtask

   task automatic test_reset_idle;
      @(negedge clk);
      check(vid_px == 1'b0,   "R1", "vid_px in reset", int'(vid_px), 0);
      check(inv_flag == 1'b0, "R1", "inv_flag in reset", int'(inv_flag), 0);
      check(vram_cs == 1'b0,  "R1", "vram_cs in reset", int'(vram_cs), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // Reset in the middle of an all-inverse line drops it at once (R1).
   task automatic test_reset_midline;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         row = 5'd12; line = 3'd2;
         disp_act = 1'b1;
         col = 5'(t / 8);
      end
      @(negedge clk);
      rst_n = 1'b0;
      disp_act = 1'b0;
      #1;
      check(vid_px == 1'b0,   "R1", "vid_px after mid-line reset", int'(vid_px), 0);
      check(inv_flag == 1'b0, "R1", "inv_flag after mid-line reset", int'(inv_flag), 0);
      check(vram_cs == 1'b0,  "R1", "vram_cs after mid-line reset", int'(vram_cs), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
      for (int i = 0; i < 768; i++) mem[i] = 8'(i * 29 + 7);
      for (int c = 0; c < 32; c++) mem[5 * 32 + c]  = (c % 2 == 1) ? 8'hFF : 8'h00;
      for (int c = 0; c < 32; c++) mem[12 * 32 + c] = 8'h80 | 8'(c * 3 + 1);
      for (int g = 0; g < 128; g++)
         for (int l = 0; l < 8; l++) mem[1024 + g * 8 + l] = 8'(font_val(g, l));

      test_reset_idle();
      run_line(0, 0, "R5");
      run_line(23, 7, "R5");
      run_line(5, 3, "R9");
      run_line(12, 4, "R6");
      run_line(12, 5, "R6");
      run_line(7, 1, "R5");
      test_reset_midline();
      run_line(3, 6, "R5");

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule